// File: doc/BRIEF.md
# Stereo Serial Audio Receiver (Clock and Frame Consumer)

This block receives a two-channel serial audio stream from an external codec that owns the bit clock and the frame sync. The three serial lines are brought into the system clock domain through a short synchronizer. A rising edge of the bit clock is detected there, and the data and sync lines are sampled at that point. Each sample is collected into a word of programmable width and written to a receive FIFO. Words are right-justified in a 32-bit entry, and each frame gives one left entry followed by one right entry. The receiver accepts standard I2S framing, where data lags the sync edge by one bit, and left-justified framing, where data starts on the sync edge. It accepts normal clock and sync polarity only: sync low selects the left channel and sync high selects the right channel.

A host reaches the block through a small register port. One register holds the run control, the framing choice, the sample length and the DMA level. A second register holds sticky error flags that are cleared by writing 1. A third register enables interrupts per flag. Reading the fourth register pops the FIFO. A DMA request is raised while the FIFO holds at least the programmed number of words. The interrupt is raised while any enabled error flag is set.

A receiver may be turned on while the codec is already clocking. In that case it stays idle until the start of the next left slot. This keeps every captured pair in left-then-right order. A slot that does not match the programmed length raises a frame error, and the incomplete word is discarded.

Top module: `i2s_rx_consumer`

## Requirements
- R1: Left-justified framing (CTRL bit 1 = 0). The MSB of a sample is sampled on the first bit-clock rising edge after the sync line changes level. A 16-bit sample (CTRL[8:4] = 15) is stored in bits 15:0 of its FIFO word, with bits 31:16 zero.
- R2: I2S framing (CTRL bit 1 = 1). The MSB is sampled on the second bit-clock rising edge after the sync change, which is one bit of delay. Storage is the same as in R1.
- R3: CTRL[8:4] holds the sample width minus one. A value of 31 yields full 32-bit words in both framings.
- R4: When the receiver is enabled (CTRL bit 0) while sync is high, no word is captured until the next sync-low (left) slot begins. From then on, FIFO words alternate left then right.
- R5: The FIFO holds 64 words in arrival order. A word completed while the FIFO is full is dropped and sets the overflow flag (STATUS bit 1).
- R6: When CTRL bit 2 is 1, dma_req is high exactly while the FIFO level is nonzero and at least the watermark in CTRL[22:16].
- R7: A sync edge before the programmed bit count, or extra bits after it, sets the frame error flag (STATUS bit 0). An early edge discards the partial word. Extra bits are ignored until the next edge.
- R8: CTRL reads back the value last written to its defined fields. While CTRL bit 0 is 0, no word enters the FIFO.
- R9: Reading DATA (address 3) while the FIFO is empty returns zero and sets the underflow flag (STATUS bit 2).
- R10: STATUS flags stay set until the host writes 1 to that bit position, and writing 0 leaves them set. irq is the OR of the flags enabled in IRQEN (address 2, bits 2:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Bit clock driven by the codec |
| ser_sync | input | 1 | Frame sync from the codec: low selects left, high selects right |
| ser_data | input | 1 | Serial sample data, MSB first |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; a read of DATA pops the FIFO |
| host_addr | input | 2 | Register select: 0 CTRL, 1 STATUS, 2 IRQEN, 3 DATA |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered one cycle after host_rd |
| dma_req | output | 1 | DMA request based on the FIFO level |
| irq | output | 1 | Interrupt from the enabled sticky flags |

## Verification
On every cycle, the checker holds the bounds and flag rules. The FIFO level never exceeds its depth. The flags stay sticky unless the host clears them. An empty-FIFO read returns zero and sets underflow. A push into a full FIFO raises overflow. A frame error reaches the status. The FIFO never fills while the receiver is off. A DMA request is never raised with an empty FIFO. Only the bench's scenarios can show the serial timing: the one-bit delay of I2S against left-justified framing, alignment to the next left slot after a mid-frame enable, which word survives a short or long slot, and the order of the words that come out.

// File: rtl/i2s_rx_pkg.sv
// Register addresses, field positions and flag indexes shared by the receiver.
package i2s_rx_pkg;
    localparam int REG_W = 32;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_STAT  = 2'd1;
    localparam logic [1:0] A_IRQEN = 2'd2;
    localparam logic [1:0] A_DATA  = 2'd3;

    localparam int CTL_EN      = 0;
    localparam int CTL_I2S     = 1;
    localparam int CTL_DMA     = 2;
    localparam int CTL_LEN_LSB = 4;
    localparam int CTL_WM_LSB  = 16;

    localparam int ST_SYNC = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_UDF  = 2;
    localparam int ST_W    = 3;
endpackage

// File: rtl/i2s_rx_sync.sv
// Brings the three serial lines into the system clock domain and marks a bit-clock
// rising edge. All three lines pass through chains of equal length, so the data and
// sync values seen with the edge pulse were sampled at the same instant.
// Assumes the system clock is at least 4x the bit clock.
module i2s_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_a,
    input  logic ws_a,
    input  logic sd_a,
    output logic bit_tick,
    output logic ws_bit,
    output logic sd_bit
);
    logic [2:0] chain [STAGES];
    logic       sclk_last;

    // first synchronizer stage captures the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= {sclk_a, ws_a, sd_a};
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // each further stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // remember the synchronized bit clock to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= chain[STAGES-1][2];
    end

    assign bit_tick = chain[STAGES-1][2] & ~sclk_last;
    assign ws_bit   = chain[STAGES-1][1];
    assign sd_bit   = chain[STAGES-1][0];
endmodule

// File: rtl/i2s_rx_deser.sv
// Slot tracker and shift register. On every bit tick it decides whether the bit
// starts a new slot, using the sync line delayed by one bit in I2S mode. It collects
// width bits per slot and emits one right-justified word per complete slot.
// Capture starts only at a left-slot start, and a wrong slot length gives an error pulse.
module i2s_rx_deser #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W),
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              i2s_mode,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              bit_tick,
    input  logic              ws_bit,
    input  logic              sd_bit,
    output logic              push,
    output logic [DATA_W-1:0] word,
    output logic              sync_err
);
    logic              ws_d1, ws_d2;
    logic              armed_q, armed_n;
    logic              bad_q, bad_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic              cur_ch, prv_ch, slot_start, took;
    logic [CNT_W-1:0]  width_c;

    // keep the last two sampled sync values for edge detection in both framings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_d1 <= 1'b0;
            ws_d2 <= 1'b0;
        end else if (bit_tick) begin
            ws_d1 <= ws_bit;
            ws_d2 <= ws_d1;
        end
    end

    assign cur_ch     = i2s_mode ? ws_d1 : ws_bit;
    assign prv_ch     = i2s_mode ? ws_d2 : ws_d1;
    assign slot_start = cur_ch != prv_ch;
    assign width_c    = CNT_W'(len_m1) + CNT_W'(1);

    // next-state logic for alignment, bit count and shift register
    always_comb begin
        armed_n  = armed_q;
        bad_n    = bad_q;
        cnt_n    = cnt_q;
        sh_n     = sh_q;
        took     = 1'b0;
        sync_err = 1'b0;
        if (!en) begin
            armed_n = 1'b0;
            bad_n   = 1'b0;
            cnt_n   = '0;
        end else if (bit_tick) begin
            if (!armed_q) begin
                if (slot_start && !cur_ch) begin
                    armed_n = 1'b1;
                    bad_n   = 1'b0;
                    sh_n    = {{(DATA_W-1){1'b0}}, sd_bit};
                    cnt_n   = CNT_W'(1);
                    took    = 1'b1;
                end
            end else if (slot_start) begin
                if (!bad_q && cnt_q != width_c) sync_err = 1'b1;
                bad_n = 1'b0;
                sh_n  = {{(DATA_W-1){1'b0}}, sd_bit};
                cnt_n = CNT_W'(1);
                took  = 1'b1;
            end else if (!bad_q) begin
                if (cnt_q == width_c) begin
                    sync_err = 1'b1;
                    bad_n    = 1'b1;
                end else begin
                    sh_n  = {sh_q[DATA_W-2:0], sd_bit};
                    cnt_n = cnt_q + CNT_W'(1);
                    took  = 1'b1;
                end
            end
        end
    end

    // register the slot state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            bad_q   <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            armed_q <= armed_n;
            bad_q   <= bad_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
        end
    end

    assign push = took && (cnt_n == width_c);
    assign word = sh_n;
endmodule

// File: rtl/i2s_rx_fifo.sv
// Receive FIFO with occupancy count. A push while full and a pop while empty are
// ignored here; the caller turns them into status flags. Read data is the head entry.
module i2s_rx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign full  = level == LW'(DEPTH);
    assign empty = level == '0;
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rp];

    // store an accepted word
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    // advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            level <= level + LW'(do_wr) - LW'(do_rd);
        end
    end
endmodule

// File: rtl/i2s_rx_consumer.sv
// Top of the serial audio receiver. It holds the host registers, the sticky flags,
// the DMA request and the interrupt, and wires together the synchronizer, the
// deserializer and the FIFO. Assumes only one host strobe is active per cycle.
module i2s_rx_consumer
    import i2s_rx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_sync,
    input  logic             ser_data,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    output logic             dma_req,
    output logic             irq
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              tick, ws_s, sd_s;
    logic              push, sync_err;
    logic [DATA_W-1:0] word, dout;
    logic              f_full, f_empty;
    logic [LVL_W-1:0]  level;

    logic              rx_en_q, i2s_q, dma_en_q;
    logic [LEN_W-1:0]  len_q;
    logic [LVL_W-1:0]  wm_q;
    logic [ST_W-1:0]   stat_q, ien_q, st_set, st_clr;
    logic [REG_W-1:0]  ctrl_word, rd_mux;
    logic              pop;

    i2s_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_a(ser_clk), .ws_a(ser_sync), .sd_a(ser_data),
        .bit_tick(tick), .ws_bit(ws_s), .sd_bit(sd_s)
    );

    i2s_rx_deser #(.DATA_W(DATA_W)) i_deser (
        .clk(clk), .rst_n(rst_n),
        .en(rx_en_q), .i2s_mode(i2s_q), .len_m1(len_q),
        .bit_tick(tick), .ws_bit(ws_s), .sd_bit(sd_s),
        .push(push), .word(word), .sync_err(sync_err)
    );

    i2s_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(word), .pop(pop),
        .dout(dout), .full(f_full), .empty(f_empty), .level(level)
    );

    assign pop = host_rd && host_addr == A_DATA;

    // host writes to the control and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q  <= 1'b0;
            i2s_q    <= 1'b0;
            dma_en_q <= 1'b0;
            len_q    <= '0;
            wm_q     <= '0;
            ien_q    <= '0;
        end else if (host_wr) begin
            case (host_addr)
                A_CTRL: begin
                    rx_en_q  <= host_wdata[CTL_EN];
                    i2s_q    <= host_wdata[CTL_I2S];
                    dma_en_q <= host_wdata[CTL_DMA];
                    len_q    <= host_wdata[CTL_LEN_LSB +: LEN_W];
                    wm_q     <= host_wdata[CTL_WM_LSB +: LVL_W];
                end
                A_IRQEN: ien_q <= host_wdata[ST_W-1:0];
                default: ;
            endcase
        end
    end

    // gather flag set events and write-one-to-clear requests
    always_comb begin
        st_set          = '0;
        st_set[ST_SYNC] = sync_err;
        st_set[ST_OVF]  = push && f_full;
        st_set[ST_UDF]  = pop && f_empty;
        st_clr = (host_wr && host_addr == A_STAT) ? host_wdata[ST_W-1:0] : '0;
    end

    // sticky flags, where a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~st_clr) | st_set;
    end

    // assemble the control readback
    always_comb begin
        ctrl_word                            = '0;
        ctrl_word[CTL_EN]                    = rx_en_q;
        ctrl_word[CTL_I2S]                   = i2s_q;
        ctrl_word[CTL_DMA]                   = dma_en_q;
        ctrl_word[CTL_LEN_LSB +: LEN_W]      = len_q;
        ctrl_word[CTL_WM_LSB +: LVL_W]       = wm_q;
    end

    // select the register being read
    always_comb begin
        case (host_addr)
            A_CTRL:  rd_mux = ctrl_word;
            A_STAT:  rd_mux = REG_W'(stat_q);
            A_IRQEN: rd_mux = REG_W'(ien_q);
            default: rd_mux = f_empty ? '0 : REG_W'(dout);
        endcase
    end

    // register read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign dma_req = dma_en_q && (level != '0) && (level >= wm_q);
    assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/i2s_rx_checker.sv
// Cycle-level properties of the receiver, attached to the top through bind.
module i2s_rx_checker
    import i2s_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_addr,
    input logic [REG_W-1:0] host_wdata,
    input logic [REG_W-1:0] host_rdata,
    input logic             rx_en_q,
    input logic             push,
    input logic             f_full,
    input logic             f_empty,
    input logic [LVL_W-1:0] level,
    input logic [ST_W-1:0]  stat_q,
    input logic             sync_err,
    input logic             dma_req
);
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push && f_full |=> stat_q[ST_OVF]);

    p_dma_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !f_empty);

    p_sync_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> stat_q[ST_SYNC]);

    p_off_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q && !host_rd |=> level <= $past(level));

    p_ctrl_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == A_CTRL |=> rx_en_q == $past(host_wdata[CTL_EN]));

    p_underflow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_addr == A_DATA && f_empty
        |=> host_rdata == '0 && stat_q[ST_UDF]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == A_STAT)
        |=> (stat_q & $past(stat_q)) == $past(stat_q));
endmodule

bind i2s_rx_consumer i2s_rx_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_en_q(rx_en_q), .push(push), .f_full(f_full), .f_empty(f_empty),
    .level(level), .stat_q(stat_q), .sync_err(sync_err), .dma_req(dma_req)
);

// File: tb/test_i2s_rx_consumer.sv
// Directed bench: a codec model drives the serial lines and a host model uses the register port.
module test_i2s_rx_consumer;
    localparam int HB = 4;   // half bit-clock period in system cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1, ser_sync = 1'b1, ser_data = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dma_req, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    bit q_ws[$];
    bit q_sd[$];

    i2s_rx_consumer i_i2s_rx_consumer (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_req(dma_req), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(bit en, bit i2s, bit dma, int width, int wm);
        logic [31:0] v = '0;
        v[0] = en; v[1] = i2s; v[2] = dma;
        v[8:4] = 5'(width - 1);
        v[22:16] = 7'(wm);
        return v;
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic read_expect(input string req, input logic [31:0] exp);
        logic [31:0] v;
        host_read(2'd3, v);
        chk(req, v, exp);
    endtask

    task automatic ser_bit(input bit ws, input bit sd);
        @(negedge clk);
        ser_clk = 1'b0; ser_sync = ws; ser_data = sd;
        repeat (HB) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    task automatic add_slot(input logic [31:0] v, input int w, input int nbits, input bit ch);
        for (int i = 0; i < nbits; i++) begin
            q_ws.push_back(ch);
            q_sd.push_back(i < w ? v[w-1-i] : 1'b0);
        end
    endtask

    task automatic add_frame(input logic [31:0] l, input logic [31:0] r, input int w);
        add_slot(l, w, w, 1'b0);
        add_slot(r, w, w, 1'b1);
    endtask

    // send the queued bits; I2S delays data by one bit and flushes the last one
    task automatic play(input bit i2s);
        bit prev = 1'b0;
        for (int p = 0; p < q_ws.size(); p++) begin
            ser_bit(q_ws[p], i2s ? prev : q_sd[p]);
            prev = q_sd[p];
        end
        if (i2s) ser_bit(1'b1, prev);
        q_ws.delete();
        q_sd.delete();
        repeat (12) @(negedge clk);
    endtask

    task automatic quiesce();
        host_write(2'd0, 32'h0);
        host_write(2'd1, 32'h7);
        host_write(2'd2, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        host_read(2'd0, v); chk("reset CTRL", v, 32'h0);
        host_read(2'd1, v); chk("reset STATUS", v, 32'h0);
        chk("reset irq", 32'(irq), 32'h0);
        chk("reset dma_req", 32'(dma_req), 32'h0);
    endtask

    task automatic t_lj16();
        logic [31:0] v;
        host_write(2'd0, ctl(1, 0, 0, 16, 1));
        add_frame(32'hA5C3, 32'h1234, 16);
        add_frame(32'hFFFF, 32'h0001, 16);
        play(1'b0);
        read_expect("R1 LJ left 0", 32'h0000A5C3);
        read_expect("R1 LJ right 0", 32'h00001234);
        read_expect("R1 LJ left 1", 32'h0000FFFF);
        read_expect("R1 LJ right 1", 32'h00000001);
        host_read(2'd1, v); chk("R1 no error flags", v, 32'h0);
        read_expect("R9 empty read is zero", 32'h0);
        host_read(2'd1, v); chk("R9 underflow flag", v, 32'h4);
        quiesce();
    endtask

    task automatic t_i2s16();
        host_write(2'd0, ctl(1, 1, 0, 16, 1));
        add_frame(32'h8001, 32'h7FFE, 16);
        add_frame(32'hC3A5, 32'h0F0F, 16);
        play(1'b1);
        read_expect("R2 I2S left 0", 32'h00008001);
        read_expect("R2 I2S right 0", 32'h00007FFE);
        read_expect("R2 I2S left 1", 32'h0000C3A5);
        read_expect("R2 I2S right 1", 32'h00000F0F);
        quiesce();
    endtask

    task automatic t_width32();
        host_write(2'd0, ctl(1, 0, 0, 32, 1));
        add_frame(32'hDEADBEEF, 32'h80000001, 32);
        play(1'b0);
        read_expect("R3 LJ 32-bit left", 32'hDEADBEEF);
        read_expect("R3 LJ 32-bit right", 32'h80000001);
        quiesce();
        host_write(2'd0, ctl(1, 1, 0, 32, 1));
        add_frame(32'h12345678, 32'hFEDCBA98, 32);
        play(1'b1);
        read_expect("R3 I2S 32-bit left", 32'h12345678);
        read_expect("R3 I2S 32-bit right", 32'hFEDCBA98);
        quiesce();
    endtask

    task automatic t_align();
        logic [31:0] v;
        // sync is high from the previous stream, so the block is enabled mid right slot
        host_write(2'd0, ctl(1, 0, 0, 16, 1));
        add_slot(32'hBAD1, 16, 16, 1'b1);
        add_frame(32'h1111, 32'h2222, 16);
        add_frame(32'h3333, 32'h4444, 16);
        play(1'b0);
        read_expect("R4 first word is left", 32'h1111);
        read_expect("R4 then right", 32'h2222);
        read_expect("R4 second left", 32'h3333);
        read_expect("R4 second right", 32'h4444);
        host_read(2'd1, v); chk("R4 no error before alignment", v, 32'h0);
        quiesce();
    endtask

    task automatic t_sync_err();
        logic [31:0] v;
        host_write(2'd0, ctl(1, 0, 0, 16, 1));
        add_slot(32'h3FF, 10, 10, 1'b0);
        add_slot(32'h5A5A, 16, 16, 1'b1);
        add_frame(32'h1357, 32'h2468, 16);
        play(1'b0);
        read_expect("R7 short slot dropped, right kept", 32'h5A5A);
        read_expect("R7 next left", 32'h1357);
        read_expect("R7 next right", 32'h2468);
        host_read(2'd1, v); chk("R7 early edge flag", v, 32'h1);
        chk("R10 irq masked", 32'(irq), 32'h0);
        host_write(2'd2, 32'h1);
        chk("R10 irq enabled", 32'(irq), 32'h1);
        host_write(2'd1, 32'h0);
        host_read(2'd1, v); chk("R10 write 0 keeps flag", v, 32'h1);
        host_write(2'd1, 32'h1);
        host_read(2'd1, v); chk("R10 write 1 clears flag", v, 32'h0);
        chk("R10 irq cleared", 32'(irq), 32'h0);
        quiesce();
        host_write(2'd0, ctl(1, 0, 0, 16, 1));
        add_slot(32'hC0DE, 16, 20, 1'b0);
        add_slot(32'h7777, 16, 16, 1'b1);
        play(1'b0);
        read_expect("R7 long slot keeps first bits", 32'hC0DE);
        read_expect("R7 long slot right", 32'h7777);
        host_read(2'd1, v); chk("R7 late edge flag", v, 32'h1);
        quiesce();
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        host_write(2'd0, ctl(1, 0, 0, 16, 1));
        for (int k = 0; k < 33; k++)
            add_frame(32'h100 + 32'(2*k), 32'h100 + 32'(2*k+1), 16);
        play(1'b0);
        host_read(2'd1, v); chk("R5 overflow flag", v, 32'h2);
        for (int i = 0; i < 64; i++)
            read_expect("R5 stored order", 32'h100 + 32'(i));
        read_expect("R5 dropped words absent", 32'h0);
        quiesce();
    endtask

    task automatic t_dma();
        logic [31:0] v;
        host_write(2'd0, ctl(1, 0, 1, 16, 3));
        add_frame(32'hAAAA, 32'hBBBB, 16);
        play(1'b0);
        chk("R6 below watermark", 32'(dma_req), 32'h0);
        add_frame(32'hCCCC, 32'hDDDD, 16);
        play(1'b0);
        chk("R6 at watermark", 32'(dma_req), 32'h1);
        host_read(2'd3, v);
        chk("R6 level 3 still requests", 32'(dma_req), 32'h1);
        host_read(2'd3, v);
        chk("R6 level 2 drops request", 32'(dma_req), 32'h0);
        host_write(2'd0, ctl(1, 0, 1, 16, 1));
        chk("R6 watermark one", 32'(dma_req), 32'h1);
        read_expect("R6 word order", 32'hCCCC);
        read_expect("R6 word order", 32'hDDDD);
        chk("R6 empty no request", 32'(dma_req), 32'h0);
        quiesce();
    endtask

    task automatic t_disable();
        logic [31:0] v;
        host_write(2'd0, 32'h000300F5);
        host_read(2'd0, v); chk("R8 CTRL readback", v, 32'h000300F5);
        host_write(2'd0, 32'h000300F4);
        host_read(2'd0, v); chk("R8 CTRL cleared enable", v, 32'h000300F4);
        add_frame(32'h9999, 32'h8888, 16);
        play(1'b0);
        chk("R8 no request while off", 32'(dma_req), 32'h0);
        read_expect("R8 nothing captured while off", 32'h0);
        host_read(2'd1, v); chk("R8 read was an underflow", v, 32'h4);
        quiesce();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        ser_bit(1'b1, 1'b0);
        ser_bit(1'b1, 1'b0);
        t_lj16();
        t_i2s16();
        t_width32();
        t_align();
        t_sync_err();
        t_overflow();
        t_dma();
        t_disable();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule